// File: doc/BRIEF.md
# Single-Character Minimum-Repetition Matcher

This block evaluates a repetition of the form "at least N copies" for a pattern element that consumes exactly one character per step: a literal, a wildcard or a character set. It sits inside a one-hot automaton that scans one character per clock. Three inputs drive it. The first is the character strobe. The second is a flag from the preceding automaton state saying the repetition may begin at this character. The third is the decoded flag saying the current character belongs to the repeated element.

The block does not lay out a chain of N state flops. It keeps one saturating run counter, whose width is the number of bits needed to hold N. When the counter reaches N the output asserts. The output then stays asserted for as long as matching characters keep arriving, and the first non-matching character drops it. The count saturates, so the block needs no record of where earlier runs began. Start flags that overlap a run in progress are absorbed without changing it.

Top module: `atl_repeat_min`

## Requirements
- R1: After N consecutive strobed matching characters, the first of which arrived with the start flag high, `run_hit` is 1 in the cycle after the clock edge that takes the N-th character.
- R2: While `run_hit` is 1, every further strobed matching character keeps it at 1, whatever the start flag is.
- R3: A strobed character with `chr_match` low clears the run, and `run_hit` is 0 after that edge. This holds even when the start flag is high on the same character.
- R4: A strobed matching character with the start flag low does not begin a run when no run is in progress. A later run still needs the full N characters.
- R5: A start flag that arrives during a run in progress neither restarts nor shortens it, so `run_hit` rises exactly N characters after the first start.
- R6: When `chr_valid` is 0, `run_hit` and the run count hold their values, whatever the other inputs are.
- R7: A synchronous `rst` sampled high makes `run_hit` 0 after the edge and empties the run count.
- R8: The run count never exceeds N. It saturates there instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| chr_valid | input | 1 | A character is present this cycle |
| prev_active | input | 1 | Preceding automaton state is active; a run may begin here |
| chr_match | input | 1 | Current character belongs to the repeated element |
| run_hit | output | 1 | N or more consecutive matches seen since an enabled start |

## Verification
Several functions can act on the same character. A start flag can arrive on the same character as a mismatch, and a start flag can arrive while a run is still counting or has already saturated. The bench forces the start-on-mismatch case directly, with the start flag and the mismatch on one strobe. It also sends start pulses in the middle of a run and after saturation. A behavioural run-length model then judges each case: the mismatch must win and leave the output low, and an overlapping start must leave the count and the cycle in which the output rises unchanged.

// File: rtl/atl_pkg.sv
package atl_pkg;
   function automatic int count_bits(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/atl_arm.sv
module atl_arm (
   input  logic chr_valid,
   input  logic prev_active,
   input  logic chr_match,
   input  logic running,
   output logic step,
   output logic clear
);
   always_comb begin
      step  = chr_valid & chr_match & (prev_active | running);
      clear = chr_valid & ~chr_match;
   end
endmodule

// File: rtl/atl_satcnt.sv
module atl_satcnt #(
   parameter int LIMIT = 8,
   parameter int W     = atl_pkg::count_bits(LIMIT)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic         clear,
   output logic [W-1:0] cnt_q,
   output logic         full
);
   localparam logic [W-1:0] TOP = W'(LIMIT);

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (step && (cnt_q != TOP))
         cnt_q <= cnt_q + 1'b1;
   end

   always_comb full = (cnt_q == TOP);
endmodule

// File: rtl/atl_repeat_min.sv
module atl_repeat_min #(
   parameter int REPS = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic chr_valid,
   input  logic prev_active,
   input  logic chr_match,
   output logic run_hit
);
   localparam int CW = atl_pkg::count_bits(REPS);

   logic          step_w;
   logic          clear_w;
   logic          running_w;
   logic [CW-1:0] cnt_w;

   if (REPS < 1) begin : g_bad_reps
      $error("atl_repeat_min: REPS must be at least 1");
   end

   atl_arm u_arm (
      .chr_valid   (chr_valid),
      .prev_active (prev_active),
      .chr_match   (chr_match),
      .running     (running_w),
      .step        (step_w),
      .clear       (clear_w)
   );

   if (REPS == 1) begin : g_single
      logic hit_q;
      always_ff @(posedge clk) begin
         if (rst)
            hit_q <= 1'b0;
         else if (clear_w)
            hit_q <= 1'b0;
         else if (step_w)
            hit_q <= 1'b1;
      end
      always_comb begin
         cnt_w     = hit_q;
         running_w = hit_q;
         run_hit   = hit_q;
      end
   end else begin : g_counter
      logic full_w;
      atl_satcnt #(.LIMIT(REPS), .W(CW)) u_cnt (
         .clk   (clk),
         .rst   (rst),
         .step  (step_w),
         .clear (clear_w),
         .cnt_q (cnt_w),
         .full  (full_w)
      );
      always_comb begin
         running_w = (cnt_w != '0);
         run_hit   = full_w;
      end
   end
endmodule

// File: rtl/atl_repeat_min_chk.sv
module atl_repeat_min_chk #(
   parameter int REPS = 5,
   parameter int W    = 3
) (
   input logic         clk,
   input logic         rst,
   input logic         chr_valid,
   input logic         prev_active,
   input logic         chr_match,
   input logic         run_hit,
   input logic [W-1:0] cnt_w
);
   localparam logic [W-1:0] TOP  = W'(REPS);
   localparam logic [W-1:0] LAST = W'(REPS - 1);

   p_reach_r1: assert property (@(posedge clk) disable iff (rst)
      (chr_valid && chr_match && prev_active && cnt_w == LAST) |=> run_hit);

   p_keep_r2: assert property (@(posedge clk) disable iff (rst)
      (run_hit && chr_valid && chr_match) |=> run_hit);

   p_miss_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (chr_valid && !chr_match) |=> (!run_hit && cnt_w == '0));

   p_no_start_r4: assert property (@(posedge clk) disable iff (rst)
      (cnt_w == '0 && chr_valid && chr_match && !prev_active) |=> (cnt_w == '0));

   p_overlap_r5: assert property (@(posedge clk) disable iff (rst)
      (chr_valid && chr_match && cnt_w != '0 && cnt_w != TOP) |=> (cnt_w == $past(cnt_w) + 1'b1));

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!chr_valid) |=> ($stable(run_hit) && $stable(cnt_w)));

   p_reset_r7: assert property (@(posedge clk)
      rst |=> (!run_hit && cnt_w == '0));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
      cnt_w <= TOP);
endmodule

bind atl_repeat_min atl_repeat_min_chk #(.REPS(REPS), .W(CW)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .chr_valid   (chr_valid),
   .prev_active (prev_active),
   .chr_match   (chr_match),
   .run_hit     (run_hit),
   .cnt_w       (cnt_w)
);

// File: tb/tb_atl_repeat_min.sv
`timescale 1ns/1ps
module tb_atl_repeat_min;
   localparam int N = 5;

   logic clk = 1'b0;
   logic rst, v, e, m;
   logic hit;
   int   vectors = 0;
   int   misses  = 0;
   int   run     = 0;
   bit   done    = 1'b0;

   always #5 clk = ~clk;

   atl_repeat_min #(.REPS(N)) dut (
      .clk(clk), .rst(rst), .chr_valid(v), .prev_active(e),
      .chr_match(m), .run_hit(hit)
   );

   // Behavioural model: run length of matches since an enabled start
   task automatic step(input bit r, input bit vv, input bit ee, input bit mm,
                       input string tag);
      bit exp_hit;
      @(negedge clk);
      rst = r; v = vv; e = ee; m = mm;
      @(posedge clk);
      if (r) run = 0;
      else if (vv) begin
         if (!mm) run = 0;
         else if (ee || run > 0) run = (run >= N) ? N : run + 1;
      end
      exp_hit = (run >= N);
      #1;
      vectors++;
      if (hit !== exp_hit) begin
         misses++;
         $display("FAIL %s: run_hit=%0b expected %0b (run %0d)", tag, hit, exp_hit, run);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         misses++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; v = 1'b0; e = 1'b0; m = 1'b0;
      step(1, 0, 0, 0, "R7 reset");
      step(1, 1, 1, 1, "R7 reset");
      // R4: matches without a start do nothing
      for (int i = 0; i < N + 2; i++) step(0, 1, 0, 1, "R4 no start");
      // R1: enabled start then N-1 more matches
      step(0, 1, 1, 1, "R1 start");
      for (int i = 0; i < N - 1; i++) step(0, 1, 0, 1, "R1 count");
      // R2/R8: stays high, enable toggling, saturated
      for (int i = 0; i < 6; i++) step(0, 1, i[0], 1, "R2 R8 hold");
      // R6: idle strobes with mismatch on the match line
      for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R6 idle");
      // R3: mismatch with start high clears
      step(0, 1, 1, 0, "R3 miss with start");
      step(0, 1, 0, 1, "R3 no run after");
      // R5: overlapping starts mid run
      step(0, 1, 1, 1, "R5 start");
      for (int i = 0; i < N - 1; i++) step(0, 1, 1, 1, "R5 overlap");
      step(0, 1, 1, 1, "R5 saturated");
      // R6 mid-run hold
      step(0, 1, 0, 0, "R3 clear");
      step(0, 1, 1, 1, "R6 start");
      step(0, 0, 0, 0, "R6 hold mid run");
      step(0, 0, 1, 1, "R6 hold mid run");
      for (int i = 0; i < N - 1; i++) step(0, 1, 0, 1, "R6 resume");
      // R7: reset while hit
      for (int i = 0; i < N; i++) step(0, 1, 1, 1, "R1 refill");
      step(1, 1, 1, 1, "R7 reset while hit");
      step(0, 1, 0, 1, "R7 after reset");
      // mixed traffic
      for (int i = 0; i < 2000; i++) begin
         bit rv, re, rm;
         rv = ($urandom % 8) != 0;
         re = ($urandom % 6) == 0;
         rm = ($urandom % 10) != 0;
         step(($urandom % 500) == 0, rv, re, rm, "R1 R2 R3 R5 mixed");
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule